// File: doc/BRIEF.md
# Flag-setting integer ALU

This block combines two operands, a 4-bit operation code and an incoming carry. It produces a result and the next set of condition flags: negative, zero, carry and overflow. Twelve operations are decoded. Six are arithmetic: add, add with carry, subtract, subtract with carry, and the two reverse forms in which the second operand is the minuend. Four are bitwise: AND, XOR, OR and bit-clear. The last two are invert-second-operand and move-second-operand. The result and the candidate flags are purely combinational.

A four-bit flag register sits behind the flag logic. It loads the candidate flags only on a cycle where the set-flags enable is high, and it holds otherwise. Every subtraction uses a single shared adder that takes an inverted operand. Carry on subtraction therefore means "no borrow". Logic operations pass the registered carry and overflow through unchanged. The block is meant to sit in an execute stage. The carry input is normally wired from the flag register by the surrounding pipeline.

Top module: `alu_flags_top`

## Requirements
- R1: The arithmetic codes produce their results modulo 2^W. The codes are 0 add (a+b), 1 add-with-carry (a+b+cin), 2 subtract (a−b), 3 subtract-with-carry (a−b+cin−1), 4 reverse subtract (b−a) and 5 reverse subtract-with-carry (b−a+cin−1).
- R2: The bitwise codes produce their results as follows: 6 gives a AND b, 7 gives a XOR b, 8 gives a OR b, 9 gives a AND NOT b, 10 gives NOT b and 11 gives b.
- R3: Codes 12 to 15 behave exactly like code 11 (move b). This applies to both the result and the flags.
- R4: flags_next is packed as {N,Z,C,V}, with N at bit 3 and V at bit 0. N equals result bit W−1. Z is 1 exactly when every result bit is 0.
- R5: For codes 0 and 1, C is the unsigned carry out of the top bit of a+b (plus cin for code 1).
- R6: For codes 2 to 5, C is 1 when no borrow occurs. With minuend m and subtrahend s, C is m≥s for codes 2 and 4. For codes 3 and 5, C is m≥s when cin=1 and m>s when cin=0.
- R7: For codes 0 and 1, V is 1 when the two addends share a sign and the result's sign differs from it.
- R8: For codes 2 to 5, V is 1 when minuend and subtrahend differ in sign and the result's sign differs from the minuend.
- R9: For codes 6 to 15, C and V in flags_next equal the C and V currently held in flags_q.
- R10: On a clock edge with set_flags high and rst low, flags_q takes the value of flags_next.
- R11: On a clock edge with set_flags low and rst low, flags_q keeps its value.
- R12: A clock edge with rst high clears flags_q to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_code | input | 4 | Operation select |
| carry_in | input | 1 | Carry used by the with-carry operations |
| set_flags | input | 1 | Load enable of the flag register |
| result | output | W | Combinational result |
| flags_next | output | 4 | Candidate flags {N,Z,C,V} |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench instantiates the block with the default W of 32. At that width the signed overflow boundaries 0x7FFFFFFF+1 and 0x80000000−1 can be applied directly, together with the all-ones carry wrap. The bench checks every flag against a reference model that works in wide signed and unsigned arithmetic rather than with an inverted-operand adder. Directed sequences cover the following: a logic operation passing a registered C=1, V=1 through unchanged, flag retention with the enable low, and a reset issued after the flags were set.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_RSB  = 4'd4,
        OP_RSC  = 4'd5,
        OP_AND  = 4'd6,
        OP_XOR  = 4'd7,
        OP_OR   = 4'd8,
        OP_BIC  = 4'd9,
        OP_NOT  = 4'd10,
        OP_MOV  = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    localparam int FLAG_BITS = $bits(alu_flags_t);

    function automatic logic op_is_arith(input logic [3:0] code);
        return code <= 4'd5;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int SW = W + 1;

    logic [W-1:0] x, y;
    logic         ci;
    logic [SW-1:0] wide;

    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        case (alu_op_e'(code))
            OP_ADC: ci = cin;
            OP_SUB: begin y = ~b; ci = 1'b1; end
            OP_SBC: begin y = ~b; ci = cin;  end
            OP_RSB: begin x = b; y = ~a; ci = 1'b1; end
            OP_RSC: begin x = b; y = ~a; ci = cin;  end
            default: ;
        endcase
    end

    assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (alu_op_e'(code))
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_BIC:  res = a & ~b;
            OP_NOT:  res = ~b;
            default: res = b;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  alu_flags_t d,
    output alu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_code,
    input  logic         carry_in,
    input  logic         set_flags,
    output logic [W-1:0] result,
    output logic [FLAG_BITS-1:0] flags_next,
    output logic [FLAG_BITS-1:0] flags_q
);
    logic [W-1:0] arith_res, logic_res;
    logic         arith_c, arith_v;
    logic         is_arith;
    alu_flags_t   nxt, cur;

    alu_addsub #(.W(W)) u_addsub (
        .code(op_code), .a(op_a), .b(op_b), .cin(carry_in),
        .sum(arith_res), .cout(arith_c), .ovf(arith_v)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .code(op_code), .a(op_a), .b(op_b), .res(logic_res)
    );

    assign is_arith = op_is_arith(op_code);
    assign result   = is_arith ? arith_res : logic_res;

    always_comb begin
        nxt.n = result[W-1];
        nxt.z = (result == '0);
        nxt.c = is_arith ? arith_c : cur.c;
        nxt.v = is_arith ? arith_v : cur.v;
    end

    alu_flag_reg u_flags (
        .clk(clk), .rst(rst), .load(set_flags), .d(nxt), .q(cur)
    );

    assign flags_next = nxt;
    assign flags_q    = cur;

endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_code,
    input logic         set_flags,
    input logic [W-1:0] result,
    input logic [3:0]   flags_next,
    input logic [3:0]   flags_q
);
    // R4: N flag mirrors the top result bit
    assert_n_msb_R4: assert property (@(posedge clk) disable iff (rst)
        flags_next[3] == result[W-1]);

    // R4: Z flag marks an all-zero result
    assert_z_zero_R4: assert property (@(posedge clk) disable iff (rst)
        flags_next[2] == (result == '0));

    // R9: logic codes pass registered C and V through
    assert_logic_keeps_cv_R9: assert property (@(posedge clk) disable iff (rst)
        (op_code >= 4'd6) |-> (flags_next[1:0] == flags_q[1:0]));

    // R10: load on enable
    assert_flags_load_R10: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flags_q == $past(flags_next)));

    // R11: hold without enable
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(flags_q));

    // R12: reset clears the register
    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (flags_q == 4'd0));
endmodule

bind alu_flags_top alu_flags_checker #(.W(W)) u_alu_flags_checker (
    .clk(clk), .rst(rst), .op_code(op_code), .set_flags(set_flags),
    .result(result), .flags_next(flags_next), .flags_q(flags_q)
);

// File: tb/alu_flags_top_bench.sv
module alu_flags_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [3:0]   code;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W-1:0] exp;
    } vec_t;

    // op, a, b, cin, expected result
    localparam vec_t TABLE [NVEC] = '{
        '{4'd0,  32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000},
        '{4'd1,  32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000},
        '{4'd2,  32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF},
        '{4'd3,  32'h00000000, 32'h00000000, 1'b0, 32'hFFFFFFFF},
        '{4'd3,  32'h00000005, 32'h00000003, 1'b1, 32'h00000002},
        '{4'd4,  32'h00000003, 32'h0000000A, 1'b0, 32'h00000007},
        '{4'd5,  32'h00000001, 32'h00000001, 1'b0, 32'hFFFFFFFF},
        '{4'd6,  32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 32'hF000F000},
        '{4'd7,  32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 32'h0FF00FF0},
        '{4'd8,  32'h0F0F0000, 32'h000000F0, 1'b0, 32'h0F0F00F0},
        '{4'd9,  32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 32'hFFFF0000},
        '{4'd10, 32'h00000000, 32'h12345678, 1'b0, 32'hEDCBA987},
        '{4'd11, 32'h11111111, 32'hCAFEBABE, 1'b0, 32'hCAFEBABE},
        '{4'd14, 32'h55555555, 32'h00000011, 1'b1, 32'h00000011}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] op_a, op_b;
    logic [3:0]   op_code;
    logic         carry_in, set_flags;
    logic [W-1:0] result;
    logic [3:0]   flags_next, flags_q;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] model_q = 4'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flags_top #(.W(W)) u_alu_flags_top (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .carry_in(carry_in), .set_flags(set_flags), .result(result),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model in wide signed/unsigned arithmetic
    task automatic model(input logic [3:0] code, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic cin, input logic [3:0] prev,
                         output logic [W-1:0] r, output logic [3:0] f);
        longint sa, sb, t;
        logic [W:0] wide;
        logic c, v;
        logic [W-1:0] m, s;
        longint sm, ss;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        c = prev[1];
        v = prev[0];
        if (code <= 4'd1) begin
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (code == 4'd1) & cin};
            r = wide[W-1:0];
            c = wide[W];
            t = sa + sb + ((code == 4'd1 && cin) ? 1 : 0);
            v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        end else if (code <= 4'd5) begin
            if (code >= 4'd4) begin m = b; s = a; sm = sb; ss = sa; end
            else              begin m = a; s = b; sm = sa; ss = sb; end
            if (code == 4'd3 || code == 4'd5) begin
                r = m - s - {{(W-1){1'b0}}, ~cin};
                c = cin ? (m >= s) : (m > s);
                t = sm - ss - (cin ? 0 : 1);
            end else begin
                r = m - s;
                c = (m >= s);
                t = sm - ss;
            end
            v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        end else begin
            case (code)
                4'd6:  r = a & b;
                4'd7:  r = a ^ b;
                4'd8:  r = a | b;
                4'd9:  r = a & ~b;
                4'd10: r = ~b;
                default: r = b;
            endcase
        end
        f = {r[W-1], (r == '0), c, v};
    endtask

    // Apply one operation, check combinational outputs, then the register
    task automatic apply(input logic [3:0] code, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic cin, input logic sf, input logic chk_res,
                         input logic [W-1:0] exp_res);
        logic [W-1:0] mr;
        logic [3:0] mf;
        string ctag, vtag, rtag;
        @(negedge clk);
        op_code = code; op_a = a; op_b = b; carry_in = cin; set_flags = sf;
        #1;
        model(code, a, b, cin, model_q, mr, mf);
        rtag = (code <= 4'd5) ? "R1" : ((code <= 4'd11) ? "R2" : "R3");
        ctag = (code <= 4'd1) ? "R5" : ((code <= 4'd5) ? "R6" : "R9");
        vtag = (code <= 4'd1) ? "R7" : ((code <= 4'd5) ? "R8" : "R9");
        if (chk_res) check(rtag, result, exp_res);
        check(rtag, result, mr);
        check("R4 N", {31'd0, flags_next[3]}, {31'd0, mf[3]});
        check("R4 Z", {31'd0, flags_next[2]}, {31'd0, mf[2]});
        check(ctag, {31'd0, flags_next[1]}, {31'd0, mf[1]});
        check(vtag, {31'd0, flags_next[0]}, {31'd0, mf[0]});
        @(posedge clk);
        #1;
        if (sf) model_q = mf;
        check(sf ? "R10" : "R11", {28'd0, flags_q}, {28'd0, model_q});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_a = '0; op_b = '0; op_code = '0; carry_in = 1'b0; set_flags = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset", {28'd0, flags_q}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++)
            apply(TABLE[i].code, TABLE[i].a, TABLE[i].b, TABLE[i].cin, 1'b1, 1'b1, TABLE[i].exp);

        // Set C=1,V=1,Z=1, then logic ops must keep C and V (R9)
        apply(4'd0, 32'h80000000, 32'h80000000, 1'b0, 1'b1, 1'b1, 32'h0);
        apply(4'd6, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1, 1'b1, 32'h80000000);
        apply(4'd12, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0);

        // Enable low: flags hold although candidate differs (R11)
        apply(4'd2, 32'h1, 32'h2, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF);
        apply(4'd0, 32'h1, 32'h1, 1'b0, 1'b0, 1'b1, 32'h2);

        // Further sweep through all codes with varied operands
        for (int k = 0; k < 16; k++)
            for (int j = 0; j < 4; j++)
                apply(4'(k), 32'h9E3779B9 * (j + 1), 32'h7F4A7C15 ^ (32'(j) << 30),
                      j[0], j[1], 1'b0, 32'h0);

        // Reset after flags were set (R12)
        apply(4'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFE);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        model_q = 4'd0;
        check("R12 reset after use", {28'd0, flags_q}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule